// File: doc/BRIEF.md
# External Interrupt Controller

This block collects 32 external interrupt lines from general-purpose pins and turns them into interrupt requests for the processor. Each pin first passes through a two-stage synchronizer. A per-line detector then watches it for the trigger kind chosen for that line: a low level, a high level, a falling edge, a rising edge or either edge. A line that fires sets a sticky pending bit. The pending bit is captured even while the line is masked.

Software drives the block over a small word-addressed register bus. It picks each line's trigger in packed 4-bit fields, blocks lines with mask bits and acknowledges events by writing ones into the pending registers. Lines 0 to 15 each raise a request output of their own. Lines 16 to 31 are folded into a single shared request, and software must read the pending registers to find the source.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset all pending bits read 0, all mask bits read 1 (masked), every trigger field reads 4'hF (disabled) and all request outputs are low.
- R2: Word address b (b = 0..3) holds the trigger fields of lines 8b..8b+7, with line k at bits [(k mod 8)*4 +: 4]. Address 4+b holds the mask bits and address 8+b holds the pending bits of the same eight lines, with line k at bit (k mod 8) and bits 31:8 reading 0. Reads are combinational from the address, and writes take effect on the clock edge that samples bus_wr_i.
- R3: Trigger codes are 0 = level low, 1 = level high, 2 = falling edge, 3 = rising edge and 4 = both edges.
- R4: A pin change driven between clock edges reaches the pending bit on the third rising edge after it, and not earlier.
- R5: An edge-triggered line sets pending once for each transition of the selected direction. Transitions of the other direction leave it unchanged.
- R6: A level-triggered line sets its pending bit on every cycle the level holds, so a clear does not stick while the level is active.
- R7: Writing 1 to a pending bit clears it, unless the line fires in the same cycle. Writing 0 leaves the bit unchanged.
- R8: A set mask bit keeps the line off every request output but still lets its pending bit be captured. Clearing the mask raises the request in the cycle after the write.
- R9: Output irq_line_o[i] (i = 0..15) is high exactly when line i is pending and unmasked, and no other line affects it.
- R10: irq_shared_o is high exactly when at least one of lines 16..31 is pending and unmasked.
- R11: A line whose trigger code is 5 to 15 never sets its pending bit, whatever its pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 32 | Asynchronous external interrupt pins |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for bus_addr_i |
| irq_line_o | output | 16 | Dedicated requests of lines 0..15 |
| irq_shared_o | output | 1 | Combined request of lines 16..31 |

## Verification
The assertions assume that pins may change at any time but that the bus strobe, address and data are synchronous to the clock and low during reset. They also assume that a pending bit can change only through a detector hit or a one-bit acknowledge. The bench drives pins and the bus only at falling clock edges and holds every unused line on a disabled trigger code. Each pending change it expects therefore comes from a single configured line and can be timed from the three-register path.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int unsigned FIELD_W = 4;

  typedef enum logic [FIELD_W-1:0] {
    TRIG_LOW  = 4'd0,
    TRIG_HIGH = 4'd1,
    TRIG_FALL = 4'd2,
    TRIG_RISE = 4'd3,
    TRIG_BOTH = 4'd4,
    TRIG_OFF  = 4'hF
  } trig_e;

  localparam logic [1:0] GRP_CFG  = 2'd0;
  localparam logic [1:0] GRP_MASK = 2'd1;
  localparam logic [1:0] GRP_PEND = 2'd2;
endpackage

// File: rtl/eic_rst_sync.sv
module eic_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic stage_q, out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_o = out_q;
endmodule

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pin_i,
  output logic [NUM_LINES-1:0] cur_o,
  output logic [NUM_LINES-1:0] prev_o
);
  logic [NUM_LINES-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/eic_detect.sv
module eic_detect
  import eic_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic [NUM_LINES-1:0]         cur_i,
  input  logic [NUM_LINES-1:0]         prev_i,
  input  logic [NUM_LINES*FIELD_W-1:0] cfg_i,
  output logic [NUM_LINES-1:0]         hit_o
);
  for (genvar gl = 0; gl < NUM_LINES; gl++) begin : g_line
    logic [FIELD_W-1:0] field;
    logic               rise, fall;

    assign field = cfg_i[gl*FIELD_W +: FIELD_W];
    assign rise  = cur_i[gl] & ~prev_i[gl];
    assign fall  = ~cur_i[gl] & prev_i[gl];

    always_comb begin
      case (field)
        TRIG_LOW:  hit_o[gl] = ~cur_i[gl];
        TRIG_HIGH: hit_o[gl] = cur_i[gl];
        TRIG_FALL: hit_o[gl] = fall;
        TRIG_RISE: hit_o[gl] = rise;
        TRIG_BOTH: hit_o[gl] = rise | fall;
        default:   hit_o[gl] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/eic_regs.sv
module eic_regs
  import eic_pkg::*;
#(
  parameter  int unsigned NUM_LINES = 32,
  parameter  int unsigned BANK_W    = 8,
  localparam int unsigned NUM_BANKS = NUM_LINES / BANK_W,
  localparam int unsigned IDX_W     = $clog2(NUM_BANKS),
  localparam int unsigned ADDR_W    = IDX_W + 2,
  localparam int unsigned DATA_W    = BANK_W * FIELD_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  input  logic [NUM_LINES-1:0]         hit_i,
  output logic [NUM_LINES*FIELD_W-1:0] cfg_o,
  output logic [NUM_LINES-1:0]         mask_o,
  output logic [NUM_LINES-1:0]         pend_o
);
  logic [1:0]           grp;
  logic [IDX_W-1:0]     idx;
  logic [DATA_W-1:0]    cfg_q [NUM_BANKS];
  logic [NUM_BANKS-1:0] cfg_we, mask_we, pend_sel;
  logic [NUM_LINES-1:0] mask_q, pend_q, pend_d, clr_vec;

  assign grp = addr_i[ADDR_W-1 -: 2];
  assign idx = addr_i[IDX_W-1:0];

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    assign cfg_we[gb]   = wr_i && (grp == GRP_CFG)  && (idx == IDX_W'(gb));
    assign mask_we[gb]  = wr_i && (grp == GRP_MASK) && (idx == IDX_W'(gb));
    assign pend_sel[gb] = wr_i && (grp == GRP_PEND) && (idx == IDX_W'(gb));
    assign clr_vec[gb*BANK_W +: BANK_W] = pend_sel[gb] ? wdata_i[BANK_W-1:0] : '0;
    assign cfg_o[gb*DATA_W +: DATA_W]   = cfg_q[gb];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[gb] <= {BANK_W{TRIG_OFF}};
      end else if (cfg_we[gb]) begin
        cfg_q[gb] <= wdata_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[gb*BANK_W +: BANK_W] <= '1;
      end else if (mask_we[gb]) begin
        mask_q[gb*BANK_W +: BANK_W] <= wdata_i[BANK_W-1:0];
      end
    end
  end

  // Detection wins over an acknowledge in the same cycle.
  always_comb begin
    pend_d = (pend_q & ~clr_vec) | hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_comb begin
    case (grp)
      GRP_CFG:  rdata_o = cfg_q[idx];
      GRP_MASK: rdata_o = {{(DATA_W-BANK_W){1'b0}}, mask_q[idx*BANK_W +: BANK_W]};
      GRP_PEND: rdata_o = {{(DATA_W-BANK_W){1'b0}}, pend_q[idx*BANK_W +: BANK_W]};
      default:  rdata_o = '0;
    endcase
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;

  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(clr_vec & ~hit_i)) == '0));

  // R6
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend_q) & ~$past(clr_vec)) & ~pend_q) == '0));

  // R11
  pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(hit_i)) == '0));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eic_pkg::*;
#(
  parameter  int unsigned NUM_LINES    = 32,
  parameter  int unsigned BANK_W       = 8,
  parameter  int unsigned DIRECT_LINES = 16,
  localparam int unsigned NUM_BANKS    = NUM_LINES / BANK_W,
  localparam int unsigned ADDR_W       = $clog2(NUM_BANKS) + 2,
  localparam int unsigned DATA_W       = BANK_W * FIELD_W
) (
  input  logic                    clk,
  input  logic                    arst_n,
  input  logic [NUM_LINES-1:0]    pin_i,
  input  logic                    bus_wr_i,
  input  logic [ADDR_W-1:0]       bus_addr_i,
  input  logic [DATA_W-1:0]       bus_wdata_i,
  output logic [DATA_W-1:0]       bus_rdata_o,
  output logic [DIRECT_LINES-1:0] irq_line_o,
  output logic                    irq_shared_o
);
  localparam int unsigned SHARED_LINES = NUM_LINES - DIRECT_LINES;

  logic                         rst_n;
  logic [NUM_LINES-1:0]         cur, prev, hit, mask, pend, active;
  logic [NUM_LINES*FIELD_W-1:0] cfg;

  eic_rst_sync i_rst_sync (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  eic_sync #(.NUM_LINES(NUM_LINES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_i),
    .cur_o  (cur),
    .prev_o (prev)
  );

  eic_detect #(.NUM_LINES(NUM_LINES)) i_detect (
    .cur_i  (cur),
    .prev_i (prev),
    .cfg_i  (cfg),
    .hit_o  (hit)
  );

  eic_regs #(.NUM_LINES(NUM_LINES), .BANK_W(BANK_W)) i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .hit_i   (hit),
    .cfg_o   (cfg),
    .mask_o  (mask),
    .pend_o  (pend)
  );

  assign active     = pend & ~mask;
  assign irq_line_o = active[DIRECT_LINES-1:0];

  if (SHARED_LINES > 0) begin : g_shared
    assign irq_shared_o = |active[NUM_LINES-1:DIRECT_LINES];

    // R10
    shared_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask[NUM_LINES-1:DIRECT_LINES]) |-> !irq_shared_o);
  end else begin : g_no_shared
    assign irq_shared_o = 1'b0;
  end

  // R8
  line_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_line_o & mask[DIRECT_LINES-1:0]) == '0));

  // R9
  line_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_line_o & ~pend[DIRECT_LINES-1:0]) == '0));
endmodule

// File: tb/test_ext_irq_ctrl.sv
module test_ext_irq_ctrl;
  logic        clk = 1'b0;
  logic        arst_n;
  logic [31:0] pins;
  logic        wr;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [15:0] irq_line;
  logic        irq_shared;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [31:0] cfg_sh [4];
  logic [7:0]  mask_sh [4];

  always #5 clk = ~clk;

  ext_irq_ctrl i_ext_irq_ctrl (
    .clk          (clk),
    .arst_n       (arst_n),
    .pin_i        (pins),
    .bus_wr_i     (wr),
    .bus_addr_i   (addr),
    .bus_wdata_i  (wdata),
    .bus_rdata_o  (rdata),
    .irq_line_o   (irq_line),
    .irq_shared_o (irq_shared)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic set_trig(input int line, input logic [3:0] t);
    cfg_sh[line/8][(line%8)*4 +: 4] = t;
    bus_write(4'(line/8), cfg_sh[line/8]);
  endtask

  task automatic set_mask(input int line, input logic m);
    mask_sh[line/8][line%8] = m;
    bus_write(4'(4 + line/8), {24'd0, mask_sh[line/8]});
  endtask

  task automatic ack(input int line);
    bus_write(4'(8 + line/8), 32'(1) << (line%8));
  endtask

  task automatic pend_bank(input int b, output logic [31:0] d);
    bus_read(4'(8 + b), d);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int b = 0; b < 4; b++) begin
      bus_read(4'(b), d);      chk("R1 cfg reset", d, 32'hFFFF_FFFF);
      bus_read(4'(4 + b), d);  chk("R1 mask reset", d, 32'h0000_00FF);
      bus_read(4'(8 + b), d);  chk("R1 pending reset", d, 32'h0);
    end
    chk("R1 line outputs", {16'd0, irq_line}, 32'h0);
    chk("R1 shared output", {31'd0, irq_shared}, 32'h0);
  endtask

  task automatic t_rising;
    logic [31:0] d;
    set_trig(3, 4'd3);
    bus_read(4'd0, d);
    chk("R2 cfg readback", d, 32'hFFFF_3FFF);
    set_mask(3, 1'b0);
    bus_read(4'd4, d);
    chk("R2 mask readback", d, 32'h0000_00F7);
    pins[3] = 1'b1;
    cycles(2);
    chk("R4 not before third edge", {16'd0, irq_line}, 32'h0);
    cycles(1);
    chk("R4 R9 rising sets line 3 only", {16'd0, irq_line}, 32'h0000_0008);
    pend_bank(0, d);
    chk("R2 pending bit position", d, 32'h0000_0008);
    ack(3);
    chk("R7 acknowledge clears", {16'd0, irq_line}, 32'h0);
    pins[3] = 1'b0;
    cycles(4);
    chk("R5 falling ignored on rising line", {16'd0, irq_line}, 32'h0);
  endtask

  task automatic t_falling;
    set_trig(5, 4'd2);
    set_mask(5, 1'b0);
    pins[5] = 1'b1;
    cycles(4);
    chk("R5 rising ignored on falling line", {16'd0, irq_line}, 32'h0);
    pins[5] = 1'b0;
    cycles(3);
    chk("R3 R5 falling sets line 5", {16'd0, irq_line}, 32'h0000_0020);
    ack(5);
    chk("R7 clear line 5", {16'd0, irq_line}, 32'h0);
  endtask

  task automatic t_both;
    logic [31:0] d;
    set_trig(20, 4'd4);
    set_mask(20, 1'b0);
    pins[20] = 1'b1;
    cycles(3);
    chk("R10 both-edge rise on shared", {31'd0, irq_shared}, 32'h1);
    pend_bank(2, d);
    chk("R2 pending bank 2 bit 4", d, 32'h0000_0010);
    ack(20);
    chk("R7 shared cleared", {31'd0, irq_shared}, 32'h0);
    pins[20] = 1'b0;
    cycles(3);
    chk("R5 both-edge fall on shared", {31'd0, irq_shared}, 32'h1);
    ack(20);
    chk("R7 shared cleared again", {31'd0, irq_shared}, 32'h0);
  endtask

  task automatic t_level_high;
    logic [31:0] d;
    set_trig(9, 4'd1);
    set_mask(9, 1'b0);
    pins[9] = 1'b1;
    cycles(3);
    chk("R3 level high sets line 9", {16'd0, irq_line}, 32'h0000_0200);
    ack(9);
    pend_bank(1, d);
    chk("R6 clear does not stick while high", d, 32'h0000_0002);
    pins[9] = 1'b0;
    cycles(4);
    ack(9);
    pend_bank(1, d);
    chk("R6 clear sticks after level ends", d, 32'h0);
  endtask

  task automatic t_level_low;
    logic [31:0] d;
    set_mask(30, 1'b0);
    set_trig(30, 4'd0);
    cycles(2);
    chk("R3 level low sets line 30", {31'd0, irq_shared}, 32'h1);
    pend_bank(3, d);
    chk("R2 pending bank 3 bit 6", d, 32'h0000_0040);
    pins[30] = 1'b1;
    cycles(4);
    ack(30);
    chk("R6 low level gone, clear sticks", {31'd0, irq_shared}, 32'h0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    set_trig(17, 4'd3);
    pins[17] = 1'b1;
    cycles(3);
    chk("R8 masked line keeps shared low", {31'd0, irq_shared}, 32'h0);
    pend_bank(2, d);
    chk("R8 pending captured while masked", d, 32'h0000_0002);
    set_mask(17, 1'b0);
    chk("R8 unmask raises shared at once", {31'd0, irq_shared}, 32'h1);
    bus_write(4'd10, 32'h0);
    pend_bank(2, d);
    chk("R7 writing zero leaves pending", d, 32'h0000_0002);
    ack(17);
    chk("R7 shared cleared after ack", {31'd0, irq_shared}, 32'h0);
  endtask

  task automatic t_boundary;
    set_trig(15, 4'd3);
    set_mask(15, 1'b0);
    pins[15] = 1'b1;
    cycles(3);
    chk("R9 line 15 dedicated output", {16'd0, irq_line}, 32'h0000_8000);
    chk("R10 line 15 not on shared", {31'd0, irq_shared}, 32'h0);
    ack(15);
    set_trig(16, 4'd3);
    set_mask(16, 1'b0);
    pins[16] = 1'b1;
    cycles(3);
    chk("R10 line 16 on shared", {31'd0, irq_shared}, 32'h1);
    chk("R9 line 16 not on dedicated", {16'd0, irq_line}, 32'h0);
    ack(16);
  endtask

  task automatic t_disabled;
    logic [31:0] d;
    set_trig(2, 4'd7);
    set_trig(6, 4'd5);
    set_mask(2, 1'b0);
    set_mask(6, 1'b0);
    for (int i = 0; i < 3; i++) begin
      pins[2] = ~pins[2];
      pins[6] = ~pins[6];
      cycles(4);
    end
    pend_bank(0, d);
    chk("R11 disabled codes never pend", d, 32'h0);
    chk("R11 disabled outputs low", {16'd0, irq_line}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; pins = '0; wr = 1'b0; addr = '0; wdata = '0;
    for (int b = 0; b < 4; b++) begin
      cfg_sh[b]  = 32'hFFFF_FFFF;
      mask_sh[b] = 8'hFF;
    end
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    cycles(4);
    t_reset();
    t_rising();
    t_falling();
    t_both();
    t_level_high();
    t_level_low();
    t_mask();
    t_boundary();
    t_disabled();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule